// File: doc/BRIEF.md
# Register Access Fault Interrupt Monitor

This block sits beside a configuration register space and watches every access made to it. Each access is sorted into three error classes. A write that lands in a partition whose lock is set is a lock fault. An access of either direction to an address outside the legal window is an address fault. An access that lacks the secure or privileged attribute its partition requires is a protection fault. Any class can fire on its own, and one access can raise more than one class.

Each class sets a sticky raw flag. Raw flags are gated by per-class enables, and the gated result drives one level-sensitive interrupt line. Enables are changed only through a write-one-to-set register and a write-one-to-clear register, so software never needs a read-modify-write. The first faulting access is also logged: its address, its class bits and its attributes. The log is frozen until software writes the re-arm bit.

The legal window, the partition size and count, and the per-partition security and privilege requirements are parameters. The lock state of each partition comes in on an input vector.

Top module: `acc_fault_mon`

## Requirements
- R1: Event bits sit at the same positions in the raw, enabled-status and enable registers: bit 2 lock fault, bit 1 address fault, bit 0 protection fault. Raw flags set whether or not the class is enabled. Raw status reads at control offset 0.
- R2: A lock fault is raised only by a write (mon_write=1) to a legal address whose partition (address >> PART_SHIFT) has its part_lock bit at 1. A read to the same address raises no lock fault.
- R3: An address fault is raised by any access, read or write, whose word address is not below LEGAL_WORDS. Such an access raises no lock or protection fault.
- R4: A protection fault is raised by a legal access to a partition listed in SEC_PARTS made with mon_secure=0. It is also raised by a legal access to a partition listed in PRIV_PARTS made with mon_priv=0.
- R5: Writing 1 to a bit at offset 2 enables that class, and writing 1 to a bit at offset 3 disables it. Zero bits leave the enable unchanged. Both offsets read back the current enables.
- R6: Offset 1 reads raw AND enable. Writing 1 to a bit there clears that raw flag. An event in the same cycle as its clear keeps the flag set.
- R7: irq is registered and equals the OR of the enabled-status bits. It updates at the same clock edge as the flags.
- R8: The first faulting access after reset or re-arm is captured. Offset 4 holds its address. Offset 5 holds its class bits at the R1 positions in bits [2:0] and a held flag in bit 3. Offset 6 holds its attributes: bit 0 write, bit 1 secure, bit 2 privileged. Later faults leave the capture unchanged while it is held.
- R9: Writing 1 to bit 0 at offset 7 clears the three capture registers and re-arms them. A fault in the same cycle as the re-arm is captured.
- R10: A control read returns its data on cfg_rdata one cycle after cfg_rd. Offsets 7 to 15 read 0. After reset every register reads 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_valid | input | 1 | A monitored access is present this cycle |
| mon_write | input | 1 | Access is a write (0 = read) |
| mon_addr | input | ADDR_W | Word address of the monitored access |
| mon_secure | input | 1 | Access carries the secure attribute |
| mon_priv | input | 1 | Access carries the privileged attribute |
| part_lock | input | NUM_PART | Lock state per partition |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_rd | input | 1 | Control register read strobe |
| cfg_addr | input | REG_AW | Control register word offset |
| cfg_wdata | input | DATA_W | Control write data |
| cfg_rdata | output | DATA_W | Registered control read data |
| irq | output | 1 | Level-sensitive interrupt |

## Verification
The bench targets the following cases, each with the fault a wrong design would show:
- A read into a locked partition. A design that ignores direction raises a spurious lock flag.
- An access past the legal window that would otherwise match a secure partition. A classifier that skips the range test also flags protection.
- An acknowledge or a re-arm in the same cycle as a new event. A design where the clear wins loses the event or the capture.
- A write of zeros to the enable set and clear registers. A design that copies the write data into the enables instead of setting or clearing bits changes them.
- A later fault after a held capture. A design that fails to freeze overwrites the first fault.

A behavioural model compares irq and every read on each clock through a long random phase.

// File: rtl/acc_fault_pkg.sv
package acc_fault_pkg;
  localparam int EV_PROT = 0;
  localparam int EV_ADDR = 1;
  localparam int EV_LOCK = 2;
  localparam int NUM_EV  = 3;

  typedef enum logic [2:0] {
    OFF_RAW    = 3'd0,
    OFF_ENSTAT = 3'd1,
    OFF_ENSET  = 3'd2,
    OFF_ENCLR  = 3'd3,
    OFF_FADDR  = 3'd4,
    OFF_FTYPE  = 3'd5,
    OFF_FATTR  = 3'd6,
    OFF_FCLR   = 3'd7
  } reg_off_e;

  typedef struct packed {
    logic priv;
    logic secure;
    logic write;
  } acc_attr_t;
endpackage

// File: rtl/acc_fault_classify.sv
module acc_fault_classify
  import acc_fault_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PART_SHIFT  = 8,
  parameter int NUM_PART    = 4,
  parameter int LEGAL_WORDS = 1000,
  parameter logic [NUM_PART-1:0] SEC_PARTS  = 4'b1100,
  parameter logic [NUM_PART-1:0] PRIV_PARTS = 4'b1010
) (
  input  logic                valid,
  input  logic                write,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                secure,
  input  logic                priv,
  input  logic [NUM_PART-1:0] part_lock,
  output logic [NUM_EV-1:0]   ev
);
  localparam int IDX_W = ADDR_W - PART_SHIFT;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(LEGAL_WORDS);

  logic                legal;
  logic [IDX_W-1:0]    idx;
  logic [NUM_PART-1:0] hit;
  logic [NUM_PART-1:0] rights_short;

  assign legal = ({1'b0, addr} < LIMIT);
  assign idx   = addr[ADDR_W-1:PART_SHIFT];

  // one decode slice per partition
  generate
    for (genvar p = 0; p < NUM_PART; p++) begin : g_part
      assign hit[p]          = legal && (idx == IDX_W'(p));
      assign rights_short[p] = (SEC_PARTS[p] && !secure) ||
                               (PRIV_PARTS[p] && !priv);
    end
  endgenerate

  always_comb begin
    ev          = '0;
    ev[EV_ADDR] = valid && !legal;
    ev[EV_LOCK] = valid && write && |(hit & part_lock);
    ev[EV_PROT] = valid && |(hit & rights_short);
  end
endmodule

// File: rtl/acc_fault_status.sv
module acc_fault_status
  import acc_fault_pkg::*;
#(
  parameter int NEV = NUM_EV
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] ev,
  input  logic [NEV-1:0] wbits,
  input  logic           set_we,
  input  logic           clr_we,
  input  logic           ack_we,
  output logic [NEV-1:0] raw_q,
  output logic [NEV-1:0] en_q,
  output logic           irq_q
);
  logic [NEV-1:0] raw_d;
  logic [NEV-1:0] en_d;

  generate
    for (genvar i = 0; i < NEV; i++) begin : g_bit
      // a new event outranks an acknowledge in the same cycle
      assign raw_d[i] = ev[i] | (raw_q[i] & ~(ack_we & wbits[i]));
      assign en_d[i]  = (set_we & wbits[i]) | (en_q[i] & ~(clr_we & wbits[i]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      en_q  <= en_d;
      irq_q <= |(raw_d & en_d);
    end
  end
endmodule

// File: rtl/acc_fault_capture.sv
module acc_fault_capture
  import acc_fault_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] ev,
  input  logic [ADDR_W-1:0] addr,
  input  acc_attr_t         attr,
  input  logic              rearm,
  output logic              held_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [NUM_EV-1:0] type_q,
  output acc_attr_t         attr_q
);
  logic take;

  // a fault arriving with the re-arm is logged, not dropped
  assign take = (|ev) && (!held_q || rearm);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      addr_q <= '0;
      type_q <= '0;
      attr_q <= '0;
    end else if (take) begin
      held_q <= 1'b1;
      addr_q <= addr;
      type_q <= ev;
      attr_q <= attr;
    end else if (rearm) begin
      held_q <= 1'b0;
      addr_q <= '0;
      type_q <= '0;
      attr_q <= '0;
    end
  end
endmodule

// File: rtl/acc_fault_mon.sv
module acc_fault_mon
  import acc_fault_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PART_SHIFT  = 8,
  parameter int NUM_PART    = 4,
  parameter int LEGAL_WORDS = 1000,
  parameter logic [NUM_PART-1:0] SEC_PARTS  = 4'b1100,
  parameter logic [NUM_PART-1:0] PRIV_PARTS = 4'b1010,
  parameter int REG_AW      = 4,
  parameter int DATA_W      = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mon_valid,
  input  logic                mon_write,
  input  logic [ADDR_W-1:0]   mon_addr,
  input  logic                mon_secure,
  input  logic                mon_priv,
  input  logic [NUM_PART-1:0] part_lock,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [REG_AW-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  output logic                irq
);
  logic [NUM_EV-1:0] ev;
  logic [NUM_EV-1:0] raw_q;
  logic [NUM_EV-1:0] en_q;
  logic              held_q;
  logic [ADDR_W-1:0] flt_addr_q;
  logic [NUM_EV-1:0] flt_type_q;
  acc_attr_t         flt_attr_q;
  acc_attr_t         acc_attr;
  logic              in_map;
  reg_off_e          off;
  logic              we_set, we_clr, we_ack, fault_clr;
  logic [DATA_W-1:0] rd_mux;

  assign acc_attr = '{priv: mon_priv, secure: mon_secure, write: mon_write};

  acc_fault_classify #(
    .ADDR_W(ADDR_W), .PART_SHIFT(PART_SHIFT), .NUM_PART(NUM_PART),
    .LEGAL_WORDS(LEGAL_WORDS), .SEC_PARTS(SEC_PARTS), .PRIV_PARTS(PRIV_PARTS)
  ) u_cls (
    .valid(mon_valid), .write(mon_write), .addr(mon_addr),
    .secure(mon_secure), .priv(mon_priv), .part_lock(part_lock), .ev(ev)
  );

  // control decode: offsets live in the low three bits, rest must be zero
  assign in_map    = (cfg_addr[REG_AW-1:3] == '0);
  assign off       = reg_off_e'(cfg_addr[2:0]);
  assign we_set    = cfg_wr && in_map && (off == OFF_ENSET);
  assign we_clr    = cfg_wr && in_map && (off == OFF_ENCLR);
  assign we_ack    = cfg_wr && in_map && (off == OFF_ENSTAT);
  assign fault_clr = cfg_wr && in_map && (off == OFF_FCLR) && cfg_wdata[0];

  acc_fault_status #(.NEV(NUM_EV)) u_stat (
    .clk(clk), .rst(rst), .ev(ev), .wbits(cfg_wdata[NUM_EV-1:0]),
    .set_we(we_set), .clr_we(we_clr), .ack_we(we_ack),
    .raw_q(raw_q), .en_q(en_q), .irq_q(irq)
  );

  acc_fault_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .ev(ev), .addr(mon_addr), .attr(acc_attr),
    .rearm(fault_clr), .held_q(held_q), .addr_q(flt_addr_q),
    .type_q(flt_type_q), .attr_q(flt_attr_q)
  );

  always_comb begin
    rd_mux = '0;
    if (in_map) begin
      case (off)
        OFF_RAW:    rd_mux = DATA_W'(raw_q);
        OFF_ENSTAT: rd_mux = DATA_W'(raw_q & en_q);
        OFF_ENSET,
        OFF_ENCLR:  rd_mux = DATA_W'(en_q);
        OFF_FADDR:  rd_mux = DATA_W'(flt_addr_q);
        OFF_FTYPE:  rd_mux = DATA_W'({held_q, flt_type_q});
        OFF_FATTR:  rd_mux = DATA_W'(flt_attr_q);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/acc_fault_mon_chk.sv
module acc_fault_mon_chk #(
  parameter int ADDR_W      = 12,
  parameter int REG_AW      = 4,
  parameter int LEGAL_WORDS = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic              mon_valid,
  input logic              mon_write,
  input logic [ADDR_W-1:0] mon_addr,
  input logic              cfg_wr,
  input logic [REG_AW-1:0] cfg_addr,
  input logic              irq,
  input logic [2:0]        raw_q,
  input logic [2:0]        en_q,
  input logic              held_q,
  input logic [ADDR_W-1:0] flt_addr_q,
  input logic              fclr
);
  localparam logic [ADDR_W:0] LIM = (ADDR_W+1)'(LEGAL_WORDS);

  AST_LOCK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_q[2]) |-> $past(mon_valid && mon_write)); // R2
  AST_ADDR_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_q[1]) |-> $past(mon_valid && ({1'b0, mon_addr} >= LIM))); // R3
  AST_ENABLE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(cfg_wr && (cfg_addr == REG_AW'(2) || cfg_addr == REG_AW'(3))) |=> $stable(en_q)); // R5
  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(cfg_wr && cfg_addr == REG_AW'(1)) |=> ((raw_q & $past(raw_q)) == $past(raw_q))); // R6
  AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    irq == |(raw_q & en_q)); // R7
  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (held_q && !fclr) |=> $stable(flt_addr_q)); // R8
endmodule

bind acc_fault_mon acc_fault_mon_chk #(
  .ADDR_W(ADDR_W), .REG_AW(REG_AW), .LEGAL_WORDS(LEGAL_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .mon_valid(mon_valid), .mon_write(mon_write),
  .mon_addr(mon_addr), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .irq(irq),
  .raw_q(raw_q), .en_q(en_q), .held_q(held_q), .flt_addr_q(flt_addr_q),
  .fclr(fault_clr)
);

// File: tb/acc_fault_mon_tb.sv
`timescale 1ns/1ps
module acc_fault_mon_tb;
  localparam int AW = 12;
  localparam int LEGAL = 1000;
  localparam logic [3:0] SECP = 4'b1100;
  localparam logic [3:0] PRVP = 4'b1010;

  logic clk = 0, rst = 1;
  logic mon_valid = 0, mon_write = 0, mon_secure = 0, mon_priv = 0;
  logic [AW-1:0] mon_addr = '0;
  logic [3:0] part_lock = '0;
  logic cfg_wr = 0, cfg_rd = 0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc_fault_mon #(
    .ADDR_W(AW), .PART_SHIFT(8), .NUM_PART(4), .LEGAL_WORDS(LEGAL),
    .SEC_PARTS(SECP), .PRIV_PARTS(PRVP), .REG_AW(4), .DATA_W(32)
  ) u_dut (.*);

  // behavioural reference
  int m_raw, m_en, m_held, m_faddr, m_ftype, m_fattr, m_rdata, m_roff;
  bit m_irq, m_rvalid;
  int ev, pidx;

  function automatic int model_read(int o);
    case (o)
      0: return m_raw;
      1: return m_raw & m_en;
      2, 3: return m_en;
      4: return m_faddr;
      5: return (m_held << 3) | m_ftype;
      6: return m_fattr;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int o);
    case (o)
      0: return "R1";
      1: return "R6";
      2, 3: return "R5";
      4, 5, 6: return "R8";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_raw = 0; m_en = 0; m_held = 0; m_faddr = 0; m_ftype = 0; m_fattr = 0;
      m_irq = 0; m_rvalid = 0; m_rdata = 0; m_roff = 0;
    end else begin
      m_rvalid = cfg_rd;
      if (cfg_rd) begin m_roff = cfg_addr; m_rdata = model_read(cfg_addr); end
      ev = 0;
      if (mon_valid) begin
        if (mon_addr >= LEGAL) ev = 2;
        else begin
          pidx = mon_addr / 256;
          if (mon_write && part_lock[pidx]) ev |= 4;
          if ((SECP[pidx] && !mon_secure) || (PRVP[pidx] && !mon_priv)) ev |= 1;
        end
      end
      if (cfg_wr && cfg_addr == 1) m_raw &= ~(cfg_wdata & 7);
      m_raw |= ev;
      if (cfg_wr && cfg_addr == 2) m_en |= (cfg_wdata & 7);
      if (cfg_wr && cfg_addr == 3) m_en &= ~(cfg_wdata & 7);
      if (cfg_wr && cfg_addr == 7 && cfg_wdata[0]) begin
        m_held = 0; m_faddr = 0; m_ftype = 0; m_fattr = 0;
      end
      if (ev != 0 && m_held == 0) begin
        m_held = 1; m_faddr = mon_addr; m_ftype = ev;
        m_fattr = {mon_priv, mon_secure, mon_write};
      end
      m_irq = ((m_raw & m_en) != 0);
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(int'(irq), int'(m_irq), "R7 irq vs model");
      if (m_rvalid) check(int'(cfg_rdata), m_rdata, tag_of(m_roff));
    end
  end

  task automatic acc(input bit w, input int a, input bit s, input bit p);
    mon_valid = 1; mon_write = w; mon_addr = AW'(a); mon_secure = s; mon_priv = p;
    @(negedge clk);
    mon_valid = 0;
  endtask

  task automatic cwr(input int o, input int d);
    cfg_wr = 1; cfg_addr = 4'(o); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic crd(input int o, input int exp, input string tag);
    cfg_rd = 1; cfg_addr = 4'(o);
    @(negedge clk);
    cfg_rd = 0;
    check(int'(cfg_rdata), exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset values
    crd(0, 0, "R10 raw after reset");
    crd(2, 0, "R10 enable after reset");
    crd(5, 0, "R10 capture after reset");
    check(int'(irq), 0, "R10 irq after reset");
    // R3 out-of-window read, also captured (R8)
    acc(0, 'h3F0, 1, 1);
    crd(0, 2, "R3 address fault flag");
    crd(4, 'h3F0, "R8 fault address");
    crd(5, 'hA, "R8 fault type with held");
    crd(6, 6, "R8 fault attributes");
    // R2 read to locked partition raises nothing
    part_lock = 4'b0010;
    acc(0, 'h130, 1, 1);
    crd(0, 2, "R2 read to locked partition");
    acc(1, 'h120, 1, 1);
    crd(0, 6, "R2 write to locked partition");
    crd(4, 'h3F0, "R8 capture not overwritten");
    // R5 enables
    cwr(2, 4);
    crd(1, 4, "R6 enabled status");
    crd(3, 4, "R5 enable readback");
    check(int'(irq), 1, "R7 irq raised");
    cwr(2, 0);
    cwr(3, 0);
    crd(2, 4, "R5 zero writes ignored");
    cwr(1, 4);
    crd(0, 2, "R6 acknowledge clears flag");
    check(int'(irq), 0, "R7 irq dropped");
    // R4 protection
    acc(0, 'h200, 0, 1);
    crd(0, 3, "R4 secure partition non-secure access");
    cwr(7, 1);
    crd(5, 0, "R9 capture cleared");
    part_lock = 4'b1010;
    acc(1, 'h300, 0, 0);
    crd(5, 'hD, "R8 lock plus protection type");
    crd(6, 1, "R8 attributes write only");
    crd(0, 7, "R1 all flags set");
    // R6 event wins over acknowledge
    cwr(2, 7);
    cfg_wr = 1; cfg_addr = 1; cfg_wdata = 1;
    acc(0, 'h200, 0, 1);
    cfg_wr = 0;
    crd(0, 7, "R6 event beats acknowledge");
    // R9 fault with re-arm is captured
    cfg_wr = 1; cfg_addr = 7; cfg_wdata = 1;
    acc(0, 'h3FF, 1, 1);
    cfg_wr = 0;
    crd(4, 'h3FF, "R9 fault during re-arm address");
    crd(5, 'hA, "R9 fault during re-arm type");
    cwr(3, 7);
    crd(1, 0, "R6 all disabled");
    check(int'(irq), 0, "R7 irq off while raw set");
    crd(0, 7, "R1 raw kept while disabled");
    crd(9, 0, "R10 unmapped offset");
    // random phase
    for (int i = 0; i < 1500; i++) begin
      mon_valid  = ($urandom_range(0, 1) == 1);
      mon_write  = $urandom_range(0, 1);
      mon_addr   = AW'($urandom_range(0, 1100));
      mon_secure = $urandom_range(0, 1);
      mon_priv   = $urandom_range(0, 1);
      part_lock  = 4'($urandom_range(0, 15));
      cfg_wr     = ($urandom_range(0, 9) < 3);
      cfg_rd     = ($urandom_range(0, 1) == 1);
      cfg_addr   = 4'($urandom_range(0, 15));
      cfg_wdata  = $urandom;
      @(negedge clk);
    end
    mon_valid = 0; cfg_wr = 0; cfg_rd = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule